// File: doc/BRIEF.md
# I2C EEPROM transaction sequencer

This block sits between a request port and a byte-level I2C bit engine. It takes one transaction request at a time and breaks it into a series of bit-engine commands: START, STOP, write one byte (the engine returns the acknowledge it sampled), and read one byte (the engine drives the acknowledge level it is told). The bit timing on the wires is left to the engine. The sequencer handles the order of the phases, the acknowledge decisions and the way errors end a transfer.

A request is one of three kinds. A **probe** checks whether a device answers at a 7-bit address. A **write** stores a run of bytes at a multi-byte internal address. A **read** fetches a run of bytes from such an address. The internal address is 0 to `ADDR_BYTES` bytes long and is sent most significant byte first. Write data arrives on a valid/ready stream. Read data leaves on a valid-only stream.

For parts that spread their memory across several bus addresses, internal address bits above the sent address bytes can be merged into the low bits of the device address under a mask. The read turnaround ends the addressing write with a full STOP and then begins again with a fresh START. Write-data bytes that are not acknowledged are counted, and the transfer carries on.

Top module: `i2c_eeprom_seq`

## Requirements
- R1: A probe (`req_op` 0; code 3 is treated the same) issues START, writes `{chip,0}`, then STOP. `present` is 1 only if that byte was acknowledged. `err` is 1 if it was not.
- R2: A read (`req_op` 2) with `req_alen` > 0 issues START, writes `{chip,0}`, writes the address bytes most significant first, then issues STOP and START, then writes `{chip,1}`.
- R3: A read with `req_alen` 0 skips the addressing phase: START, then write `{chip,1}` at once.
- R4: In a read, every READ command except the last has `eng_cmd_nack` 0. The last has it at 1, and a STOP follows. Each received byte appears once on `rd_data` with `rd_valid`, in order.
- R5: If `{chip,0}` is not acknowledged in a read or write, the next command is STOP and the transaction ends with `err` 1. No address or data byte is sent.
- R6: If an internal address byte is not acknowledged, the next command is STOP and the transaction ends with `err` 1. No write data is taken from the stream.
- R7: In a write (`req_op` 1), a data byte that is not acknowledged does not stop the transfer. All `req_count` bytes are taken from the write stream (`wr_valid`/`wr_ready`) and sent, then STOP. `fail_count` equals the number of unacknowledged data bytes, and `err` stays 0.
- R8: For reads and writes, the device address sent is `chip | ((addr >> 8*alen) & ovf_mask)`. With `ovf_mask` 0 the device address is unchanged.
- R9: If the read-direction `{chip,1}` byte is not acknowledged, `rd_chip_nack` is 1 at `done`, and all data bytes are still read.
- R10: With `req_count` 0, a write ends with STOP right after the address bytes, and a read ends with STOP right after `{chip,1}`.
- R11: Command codes on `eng_cmd` are 0 START, 1 STOP, 2 WRITE, 3 READ. `eng_cmd_valid` is a one-cycle pulse, and no new command is issued until `eng_done` answers the previous one.
- R12: `req_ready` is 1 only between transactions. A `req_valid` while busy is ignored and issues no commands.
- R13: After reset, `req_ready` is 1 and `eng_cmd_valid`, `wr_ready`, `rd_valid` and `done` are 0. Every transaction's last command is STOP, and `done` pulses for one cycle after that STOP completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle if valid |
| req_op | input | 2 | 0 probe, 1 write, 2 read |
| req_chip | input | 7 | Device address |
| req_addr | input | 8*ADDR_BYTES | Internal address |
| req_alen | input | ALEN_W | Internal address length in bytes |
| req_count | input | CNT_W | Number of data bytes |
| ovf_mask | input | 7 | Mask for folding high address bits into the device address |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken this cycle if valid |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| eng_cmd_valid | output | 1 | Command pulse to the bit engine |
| eng_cmd | output | 2 | Command code |
| eng_cmd_byte | output | 8 | Byte to write |
| eng_cmd_nack | output | 1 | Acknowledge level to send after a READ (1 = NACK) |
| eng_done | input | 1 | Engine finished the last command |
| eng_rx_byte | input | 8 | Byte received by a READ |
| eng_rx_nack | input | 1 | Acknowledge sampled after a WRITE (1 = NACK) |
| done | output | 1 | Transaction finished (one cycle) |
| err | output | 1 | Device or address byte not acknowledged |
| present | output | 1 | Probe result |
| rd_chip_nack | output | 1 | Read-direction device byte not acknowledged |
| fail_count | output | CNT_W | Unacknowledged write-data bytes |

## Verification
The bench goes after the read turnaround. A design that used a repeated START, or dropped the STOP between phases, shows a different command trace. It tests a zero-length address read, which a careless design would still open with a write-direction device byte. It injects NACKs on data, on address bytes and on both device-byte directions. A design that aborted on data NACKs would show a short trace and a wrong `fail_count`. One that kept going after an address NACK would send more bytes or drain the write stream. It checks folding with a nonzero and a zero mask, zero-byte counts, and a request pulse made while busy, which a faulty design would turn into extra commands.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [1:0] {
    BC_START = 2'd0,
    BC_STOP  = 2'd1,
    BC_WRITE = 2'd2,
    BC_READ  = 2'd3
  } bit_cmd_e;

  typedef enum logic [1:0] {
    OP_PROBE = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_ALT   = 2'd3
  } req_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_CHIPW,
    ST_ADDR,
    ST_MIDSTOP,
    ST_RESTART,
    ST_CHIPR,
    ST_RDATA,
    ST_WFETCH,
    ST_WDATA,
    ST_STOP
  } seq_state_e;

endpackage

// File: rtl/i2cs_fold.sv
// Merges internal address bits above the sent bytes into the device address.
module i2cs_fold #(
  parameter int ADDR_BYTES = 4,
  localparam int ADDR_W = 8 * ADDR_BYTES,
  localparam int ALEN_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ALEN_W-1:0] alen,
  input  logic [6:0]        chip,
  input  logic [6:0]        mask,
  output logic [6:0]        chip_out
);
  logic [ADDR_W-1:0] upper;

  assign upper    = addr >> {alen, 3'b000};
  assign chip_out = chip | (upper[6:0] & mask);
endmodule

// File: rtl/i2cs_addr_pick.sv
// Selects the internal address byte to send, most significant first.
module i2cs_addr_pick #(
  parameter int ADDR_BYTES = 4,
  localparam int ADDR_W = 8 * ADDR_BYTES,
  localparam int ALEN_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ALEN_W-1:0] alen,
  input  logic [ALEN_W-1:0] idx,
  output logic [7:0]        byte_out
);
  logic [7:0]        lanes [ADDR_BYTES];
  logic [ALEN_W-1:0] sel;

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
    assign lanes[g] = addr[8*g +: 8];
  end

  assign sel = alen - idx - ALEN_W'(1);

  always_comb begin
    byte_out = 8'h00;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (sel == ALEN_W'(i)) byte_out = lanes[i];
    end
  end
endmodule

// File: rtl/i2cs_tally.sv
// Saturating counter of unacknowledged write-data bytes.
module i2cs_tally #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (inc && (count != {CNT_W{1'b1}})) begin
      count <= count + CNT_W'(1);
    end
  end
endmodule

// File: rtl/i2c_eeprom_seq.sv
module i2c_eeprom_seq
  import i2cs_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int CNT_W = 8,
  localparam int ADDR_W = 8 * ADDR_BYTES,
  localparam int ALEN_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [6:0]        req_chip,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ALEN_W-1:0] req_alen,
  input  logic [CNT_W-1:0]  req_count,
  input  logic [6:0]        ovf_mask,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              eng_cmd_valid,
  output logic [1:0]        eng_cmd,
  output logic [7:0]        eng_cmd_byte,
  output logic              eng_cmd_nack,
  input  logic              eng_done,
  input  logic [7:0]        eng_rx_byte,
  input  logic              eng_rx_nack,
  output logic              done,
  output logic              err,
  output logic              present,
  output logic              rd_chip_nack,
  output logic [CNT_W-1:0]  fail_count
);

  seq_state_e        state_q;
  logic              wait_q;
  req_op_e           op_q;
  logic [6:0]        chip_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ALEN_W-1:0] alen_q;
  logic [CNT_W-1:0]  remain_q;
  logic [ALEN_W-1:0] idx_q;
  logic [7:0]        wbyte_q;
  logic              err_q, present_q, rdn_q;

  logic              cmd_valid_q, cmd_nack_q;
  logic [1:0]        cmd_q;
  logic [7:0]        cmd_byte_q;
  logic              rd_valid_q, done_q, err_o, present_o, rdn_o;
  logic [7:0]        rd_data_q;

  logic              accept, fetch, issue, resp;
  logic              need_cmd, nxt_nack;
  bit_cmd_e          nxt_cmd;
  logic [7:0]        nxt_byte;
  logic [ALEN_W-1:0] alen_in;
  logic [6:0]        chip_fold;
  logic [7:0]        addr_byte;
  logic              tally_inc;
  seq_state_e        after_addr;

  assign req_ready = (state_q == ST_IDLE);
  assign wr_ready  = (state_q == ST_WFETCH);
  assign accept    = req_valid && req_ready;
  assign fetch     = wr_ready && wr_valid;
  assign resp      = wait_q && eng_done;
  assign alen_in   = (req_alen > ALEN_W'(ADDR_BYTES)) ? ALEN_W'(ADDR_BYTES) : req_alen;

  i2cs_fold #(.ADDR_BYTES(ADDR_BYTES)) u_fold (
    .addr     (req_addr),
    .alen     (alen_in),
    .chip     (req_chip),
    .mask     (ovf_mask),
    .chip_out (chip_fold)
  );

  i2cs_addr_pick #(.ADDR_BYTES(ADDR_BYTES)) u_pick (
    .addr     (addr_q),
    .alen     (alen_q),
    .idx      (idx_q),
    .byte_out (addr_byte)
  );

  assign tally_inc = resp && eng_rx_nack && (state_q == ST_WDATA);

  i2cs_tally #(.CNT_W(CNT_W)) u_tally (
    .clk   (clk),
    .rst   (rst),
    .clr   (accept),
    .inc   (tally_inc),
    .count (fail_count)
  );

  // Command owed by each state.
  always_comb begin
    need_cmd = 1'b1;
    nxt_cmd  = BC_START;
    nxt_byte = 8'h00;
    nxt_nack = 1'b0;
    unique case (state_q)
      ST_START, ST_RESTART: nxt_cmd = BC_START;
      ST_MIDSTOP, ST_STOP:  nxt_cmd = BC_STOP;
      ST_CHIPW: begin nxt_cmd = BC_WRITE; nxt_byte = {chip_q, 1'b0}; end
      ST_CHIPR: begin nxt_cmd = BC_WRITE; nxt_byte = {chip_q, 1'b1}; end
      ST_ADDR:  begin nxt_cmd = BC_WRITE; nxt_byte = addr_byte; end
      ST_WDATA: begin nxt_cmd = BC_WRITE; nxt_byte = wbyte_q; end
      ST_RDATA: begin nxt_cmd = BC_READ;  nxt_nack = (remain_q == CNT_W'(1)); end
      default:  need_cmd = 1'b0;
    endcase
  end

  assign issue = need_cmd && !wait_q;

  // Where the transfer goes once the address phase is complete.
  always_comb begin
    if (op_q == OP_READ)               after_addr = ST_MIDSTOP;
    else if (remain_q != '0)           after_addr = ST_WFETCH;
    else                               after_addr = ST_STOP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      wait_q      <= 1'b0;
      op_q        <= OP_PROBE;
      chip_q      <= '0;
      addr_q      <= '0;
      alen_q      <= '0;
      remain_q    <= '0;
      idx_q       <= '0;
      wbyte_q     <= '0;
      err_q       <= 1'b0;
      present_q   <= 1'b0;
      rdn_q       <= 1'b0;
      cmd_valid_q <= 1'b0;
      cmd_q       <= BC_START;
      cmd_byte_q  <= '0;
      cmd_nack_q  <= 1'b0;
      rd_valid_q  <= 1'b0;
      rd_data_q   <= '0;
      done_q      <= 1'b0;
      err_o       <= 1'b0;
      present_o   <= 1'b0;
      rdn_o       <= 1'b0;
    end else begin
      cmd_valid_q <= 1'b0;
      rd_valid_q  <= 1'b0;
      done_q      <= 1'b0;

      if (accept) begin
        op_q      <= req_op_e'(req_op);
        chip_q    <= (req_op == OP_WRITE || req_op == OP_READ) ? chip_fold : req_chip;
        addr_q    <= req_addr;
        alen_q    <= alen_in;
        remain_q  <= req_count;
        idx_q     <= '0;
        err_q     <= 1'b0;
        present_q <= 1'b0;
        rdn_q     <= 1'b0;
        wait_q    <= 1'b0;
        state_q   <= ST_START;
      end else if (issue) begin
        cmd_valid_q <= 1'b1;
        cmd_q       <= nxt_cmd;
        cmd_byte_q  <= nxt_byte;
        cmd_nack_q  <= nxt_nack;
        wait_q      <= 1'b1;
      end else if (fetch) begin
        wbyte_q <= wr_data;
        state_q <= ST_WDATA;
      end else if (resp) begin
        wait_q <= 1'b0;
        unique case (state_q)
          ST_START: begin
            state_q <= (op_q == OP_READ && alen_q == '0) ? ST_CHIPR : ST_CHIPW;
          end
          ST_CHIPW: begin
            if (eng_rx_nack) begin
              err_q   <= 1'b1;
              state_q <= ST_STOP;
            end else if (op_q != OP_WRITE && op_q != OP_READ) begin
              present_q <= 1'b1;
              state_q   <= ST_STOP;
            end else if (alen_q != '0) begin
              state_q <= ST_ADDR;
            end else begin
              state_q <= after_addr;
            end
          end
          ST_ADDR: begin
            if (eng_rx_nack) begin
              err_q   <= 1'b1;
              state_q <= ST_STOP;
            end else if (ALEN_W'(idx_q + ALEN_W'(1)) == alen_q) begin
              state_q <= after_addr;
            end else begin
              idx_q <= idx_q + ALEN_W'(1);
            end
          end
          ST_MIDSTOP: state_q <= ST_RESTART;
          ST_RESTART: state_q <= ST_CHIPR;
          ST_CHIPR: begin
            rdn_q   <= eng_rx_nack;
            state_q <= (remain_q != '0) ? ST_RDATA : ST_STOP;
          end
          ST_RDATA: begin
            rd_valid_q <= 1'b1;
            rd_data_q  <= eng_rx_byte;
            remain_q   <= remain_q - CNT_W'(1);
            if (remain_q == CNT_W'(1)) state_q <= ST_STOP;
          end
          ST_WDATA: begin
            remain_q <= remain_q - CNT_W'(1);
            state_q  <= (remain_q == CNT_W'(1)) ? ST_STOP : ST_WFETCH;
          end
          ST_STOP: begin
            done_q    <= 1'b1;
            err_o     <= err_q;
            present_o <= present_q;
            rdn_o     <= rdn_q;
            state_q   <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign eng_cmd_valid = cmd_valid_q;
  assign eng_cmd       = cmd_q;
  assign eng_cmd_byte  = cmd_byte_q;
  assign eng_cmd_nack  = cmd_nack_q;
  assign rd_valid      = rd_valid_q;
  assign rd_data       = rd_data_q;
  assign done          = done_q;
  assign err           = err_o;
  assign present       = present_o;
  assign rd_chip_nack  = rdn_o;

endmodule

// File: rtl/i2cs_seq_checker.sv
module i2cs_seq_checker (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic       eng_cmd_valid,
  input logic [1:0] eng_cmd,
  input logic       eng_done,
  input logic       done,
  input logic       rd_valid,
  input logic       wr_ready
);
  logic       outstanding;
  logic [1:0] last_cmd;

  always_ff @(posedge clk) begin
    if (rst) begin
      outstanding <= 1'b0;
      last_cmd    <= 2'd0;
    end else if (eng_cmd_valid) begin
      outstanding <= 1'b1;
      last_cmd    <= eng_cmd;
    end else if (eng_done) begin
      outstanding <= 1'b0;
    end
  end

  // R11: a new command waits for the engine to answer the previous one
  p_single_outstanding_r11: assert property (@(posedge clk) disable iff (rst)
    outstanding |-> !eng_cmd_valid);

  // R1: every accepted request opens with START two cycles later
  p_opens_with_start_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> ##1 (eng_cmd_valid && eng_cmd == 2'd0));

  // R12: accepting a request leaves the idle state
  p_busy_after_accept_r12: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R13: completion only after a STOP that the engine has answered
  p_done_after_stop_r13: assert property (@(posedge clk) disable iff (rst)
    done |-> (last_cmd == 2'd1 && !outstanding));

  // R4: a read byte is delivered only right after an engine answer
  p_rd_follows_engine_r4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(eng_done));

  // R7: write data is fetched only with no command in flight
  p_fetch_when_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    wr_ready |-> !outstanding);
endmodule

bind i2c_eeprom_seq i2cs_seq_checker u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .eng_cmd_valid (eng_cmd_valid),
  .eng_cmd       (eng_cmd),
  .eng_done      (eng_done),
  .done          (done),
  .rd_valid      (rd_valid),
  .wr_ready      (wr_ready)
);

// File: tb/i2c_eeprom_seq_test.sv
module i2c_eeprom_seq_test;
  localparam int ADDR_BYTES = 4;
  localparam int CNT_W = 8;
  localparam int ADDR_W = 32;
  localparam int ALEN_W = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [1:0]        req_op = 2'd0;
  logic [6:0]        req_chip = 7'd0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [ALEN_W-1:0] req_alen = '0;
  logic [CNT_W-1:0]  req_count = '0;
  logic [6:0]        ovf_mask = 7'd0;
  logic              wr_valid = 1'b0;
  logic              wr_ready;
  logic [7:0]        wr_data = 8'd0;
  logic              rd_valid;
  logic [7:0]        rd_data;
  logic              eng_cmd_valid;
  logic [1:0]        eng_cmd;
  logic [7:0]        eng_cmd_byte;
  logic              eng_cmd_nack;
  logic              eng_done = 1'b0;
  logic [7:0]        eng_rx_byte = 8'd0;
  logic              eng_rx_nack = 1'b0;
  logic              done, err, present, rd_chip_nack;
  logic [CNT_W-1:0]  fail_count;

  i2c_eeprom_seq #(.ADDR_BYTES(ADDR_BYTES), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_chip(req_chip), .req_addr(req_addr), .req_alen(req_alen),
    .req_count(req_count), .ovf_mask(ovf_mask), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
    .eng_cmd_valid(eng_cmd_valid), .eng_cmd(eng_cmd), .eng_cmd_byte(eng_cmd_byte),
    .eng_cmd_nack(eng_cmd_nack), .eng_done(eng_done), .eng_rx_byte(eng_rx_byte),
    .eng_rx_nack(eng_rx_nack), .done(done), .err(err), .present(present),
    .rd_chip_nack(rd_chip_nack), .fail_count(fail_count)
  );

  always #10 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  int    cmd_seen = 0;
  string tag = "R13";

  logic [10:0] exp_cmd [$];
  logic [7:0]  exp_rd [$];
  logic [7:0]  wq [$];

  // behavioural EEPROM behind an ideal bit engine
  logic [7:0] m_mem [1024];
  int         m_phase = 0;
  int         m_cnt = 0;
  int         m_ptr = 0;
  int         m_alen = 1;
  int         m_acc = 0;
  bit         m_rsel = 1'b0;
  bit         m_addr_nack = 1'b0;
  int         delay = 0;
  logic [7:0] resp_b = 8'h00;
  logic       resp_n = 1'b0;

  function automatic logic [7:0] init_val(input int i);
    return 8'(i) ^ 8'h5C;
  endfunction

  task automatic check_eq(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic e(input logic [1:0] c, input logic [7:0] b, input logic n);
    exp_cmd.push_back({c, b, n});
  endtask

  task automatic model(input logic [1:0] c, input logic [7:0] b);
    resp_b = 8'hFF;
    resp_n = 1'b1;
    case (c)
      2'd0: m_phase = 1;
      2'd1: m_phase = 0;
      2'd2: begin
        if (m_phase == 1) begin
          if (b[0]) begin
            m_rsel  = (b[7:3] == 5'b10100);
            resp_n  = !m_rsel;
            m_phase = 4;
          end else if (b[7:3] == 5'b10100) begin
            resp_n = 1'b0; m_phase = 2; m_acc = int'(b[2:1]); m_cnt = 0;
          end else begin
            m_phase = 0;
          end
        end else if (m_phase == 2) begin
          if (m_addr_nack) m_phase = 0;
          else begin
            resp_n = 1'b0;
            m_acc  = (m_acc << 8) | int'(b);
            m_cnt++;
            if (m_cnt == m_alen) begin m_ptr = m_acc & 1023; m_phase = 3; end
          end
        end else if (m_phase == 3) begin
          if (b != 8'hEE) begin
            resp_n = 1'b0;
            m_mem[m_ptr] = b;
            m_ptr = (m_ptr + 1) & 1023;
          end
        end
      end
      default: begin
        if (m_phase == 4 && m_rsel) begin
          resp_b = m_mem[m_ptr];
          m_ptr  = (m_ptr + 1) & 1023;
        end
      end
    endcase
  endtask

  // engine model and scoreboard monitor
  initial begin
    logic [10:0] got;
    logic [10:0] want;
    for (int i = 0; i < 1024; i++) m_mem[i] = init_val(i);
    forever begin
      @(negedge clk);
      eng_done = 1'b0;
      if (delay > 0) begin
        delay--;
        if (delay == 0) begin
          eng_done = 1'b1; eng_rx_byte = resp_b; eng_rx_nack = resp_n;
        end
      end
      if (eng_cmd_valid) begin
        cmd_seen++;
        got = {eng_cmd, (eng_cmd == 2'd3) ? 8'h00 : eng_cmd_byte, eng_cmd_nack};
        if (exp_cmd.size() == 0) begin
          check_eq({tag, " unexpected command (R11 R12)"}, int'(got), 0);
        end else begin
          want = exp_cmd.pop_front();
          check_eq({tag, " command trace {cmd,byte,nack}"}, int'(got), int'(want));
        end
        model(eng_cmd, eng_cmd_byte);
        delay = 3;
      end
      if (rd_valid) begin
        if (exp_rd.size() == 0) check_eq({tag, " unexpected read byte R4"}, int'(rd_data), 0);
        else check_eq({tag, " read stream byte R4"}, int'(rd_data), int'(exp_rd.pop_front()));
      end
    end
  end

  // write-data stream driver
  initial begin
    bit take = 1'b0;
    forever begin
      @(negedge clk);
      if (take && wq.size() > 0) void'(wq.pop_front());
      wr_valid = (wq.size() > 0);
      wr_data  = (wq.size() > 0) ? wq[0] : 8'h00;
      take     = wr_valid && wr_ready;
    end
  end

  task automatic run(input logic [1:0] op, input logic [6:0] chip, input logic [31:0] addr,
                     input logic [2:0] alen, input logic [7:0] cnt, input logic [6:0] mask,
                     input bit poke);
    int n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = op; req_chip = chip; req_addr = addr; req_alen = alen;
    req_count = cnt; ovf_mask = mask; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done) begin
      @(negedge clk);
      n++;
      if (poke && n == 4) begin
        check_eq({tag, " req_ready while busy"}, int'(req_ready), 0);
        req_op = 2'd0; req_chip = 7'h33; req_valid = 1'b1;
      end else begin
        req_valid = 1'b0;
      end
    end
    req_valid = 1'b0;
    check_eq({tag, " remaining expected commands"}, exp_cmd.size(), 0);
    check_eq({tag, " remaining expected read bytes"}, exp_rd.size(), 0);
  endtask

  localparam logic [1:0] S = 2'd0, P = 2'd1, W = 2'd2, RD = 2'd3;

  initial begin
    int seen;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    tag = "R13";
    check_eq("R13 reset req_ready", int'(req_ready), 1);
    check_eq("R13 reset eng_cmd_valid", int'(eng_cmd_valid), 0);
    check_eq("R13 reset wr_ready", int'(wr_ready), 0);
    check_eq("R13 reset rd_valid/done", int'({rd_valid, done}), 0);

    // probe of a present device
    tag = "R1 R11";
    e(S, 8'h00, 0); e(W, 8'hA0, 0); e(P, 8'h00, 0);
    run(2'd0, 7'h50, 0, 0, 0, 7'h03, 0);
    check_eq("R1 present", int'(present), 1);
    check_eq("R1 err", int'(err), 0);

    // probe of an absent device
    tag = "R1";
    e(S, 8'h00, 0); e(W, 8'h66, 0); e(P, 8'h00, 0);
    run(2'd0, 7'h33, 0, 0, 0, 7'h03, 0);
    check_eq("R1 absent present", int'(present), 0);
    check_eq("R1 absent err", int'(err), 1);

    // plain write
    tag = "R7";
    e(S, 0, 0); e(W, 8'hA0, 0); e(W, 8'h10, 0);
    e(W, 8'h11, 0); e(W, 8'h22, 0); e(W, 8'h33, 0); e(P, 0, 0);
    wq.push_back(8'h11); wq.push_back(8'h22); wq.push_back(8'h33);
    run(2'd1, 7'h50, 32'h10, 1, 3, 7'h03, 0);
    check_eq("R7 fail_count clean", int'(fail_count), 0);
    check_eq("R7 write stream drained", wq.size(), 0);

    // read with turnaround
    tag = "R2 R4";
    e(S, 0, 0); e(W, 8'hA0, 0); e(W, 8'h10, 0); e(P, 0, 0); e(S, 0, 0); e(W, 8'hA1, 0);
    e(RD, 0, 0); e(RD, 0, 0); e(RD, 0, 1); e(P, 0, 0);
    exp_rd.push_back(8'h11); exp_rd.push_back(8'h22); exp_rd.push_back(8'h33);
    run(2'd2, 7'h50, 32'h10, 1, 3, 7'h03, 0);
    check_eq("R2 err", int'(err), 0);

    // zero-length address read continues at 0x13
    tag = "R3";
    e(S, 0, 0); e(W, 8'hA1, 0); e(RD, 0, 0); e(RD, 0, 1); e(P, 0, 0);
    exp_rd.push_back(init_val(32'h13)); exp_rd.push_back(init_val(32'h14));
    run(2'd2, 7'h50, 32'h0, 0, 2, 7'h03, 0);

    // fold high address bits into the device address
    tag = "R8";
    e(S, 0, 0); e(W, 8'hA4, 0); e(W, 8'h40, 0); e(W, 8'h5A, 0); e(W, 8'hA5, 0); e(P, 0, 0);
    wq.push_back(8'h5A); wq.push_back(8'hA5);
    run(2'd1, 7'h50, 32'h240, 1, 2, 7'h03, 0);
    e(S, 0, 0); e(W, 8'hA4, 0); e(W, 8'h40, 0); e(P, 0, 0); e(S, 0, 0); e(W, 8'hA5, 0);
    e(RD, 0, 0); e(RD, 0, 1); e(P, 0, 0);
    exp_rd.push_back(8'h5A); exp_rd.push_back(8'hA5);
    run(2'd2, 7'h50, 32'h240, 1, 2, 7'h03, 0);

    // zero mask leaves the device address alone
    e(S, 0, 0); e(W, 8'hA0, 0); e(W, 8'h40, 0); e(P, 0, 0); e(S, 0, 0); e(W, 8'hA1, 0);
    e(RD, 0, 1); e(P, 0, 0);
    exp_rd.push_back(init_val(32'h40));
    run(2'd2, 7'h50, 32'h240, 1, 1, 7'h00, 0);

    // data NACKs are counted, transfer continues
    tag = "R7";
    e(S, 0, 0); e(W, 8'hA0, 0); e(W, 8'h80, 0);
    e(W, 8'h01, 0); e(W, 8'hEE, 0); e(W, 8'h02, 0); e(W, 8'hEE, 0); e(P, 0, 0);
    wq.push_back(8'h01); wq.push_back(8'hEE); wq.push_back(8'h02); wq.push_back(8'hEE);
    run(2'd1, 7'h50, 32'h80, 1, 4, 7'h03, 0);
    check_eq("R7 fail_count", int'(fail_count), 2);
    check_eq("R7 err with data NACKs", int'(err), 0);
    check_eq("R7 stream drained", wq.size(), 0);

    // device NACK in the write-direction phase
    tag = "R5";
    e(S, 0, 0); e(W, 8'h60, 0); e(P, 0, 0);
    run(2'd2, 7'h30, 32'h10, 1, 2, 7'h03, 0);
    check_eq("R5 err", int'(err), 1);

    // address byte NACK
    tag = "R6";
    m_alen = 2; m_addr_nack = 1'b1;
    e(S, 0, 0); e(W, 8'hA0, 0); e(W, 8'h01, 0); e(P, 0, 0);
    wq.push_back(8'h77);
    run(2'd1, 7'h50, 32'h0123, 2, 1, 7'h03, 0);
    check_eq("R6 err", int'(err), 1);
    check_eq("R6 write byte left in stream", wq.size(), 1);
    wq.delete();
    m_addr_nack = 1'b0;

    // read-direction device NACK
    tag = "R9";
    e(S, 0, 0); e(W, 8'h61, 0); e(RD, 0, 0); e(RD, 0, 1); e(P, 0, 0);
    exp_rd.push_back(8'hFF); exp_rd.push_back(8'hFF);
    run(2'd2, 7'h30, 32'h0, 0, 2, 7'h03, 0);
    check_eq("R9 rd_chip_nack", int'(rd_chip_nack), 1);
    check_eq("R9 err", int'(err), 0);

    // zero byte counts
    tag = "R10";
    e(S, 0, 0); e(W, 8'hA0, 0); e(W, 8'h03, 0); e(W, 8'h05, 0); e(P, 0, 0);
    run(2'd1, 7'h50, 32'h0305, 2, 0, 7'h03, 0);
    check_eq("R10 write err", int'(err), 0);
    e(S, 0, 0); e(W, 8'hA1, 0); e(P, 0, 0);
    run(2'd2, 7'h50, 32'h0, 0, 0, 7'h03, 0);
    check_eq("R10 read rd_chip_nack", int'(rd_chip_nack), 0);

    // two-byte address, most significant first
    tag = "R2";
    e(S, 0, 0); e(W, 8'hA0, 0); e(W, 8'h03, 0); e(W, 8'h05, 0); e(W, 8'h77, 0); e(P, 0, 0);
    wq.push_back(8'h77);
    run(2'd1, 7'h50, 32'h0305, 2, 1, 7'h03, 0);
    e(S, 0, 0); e(W, 8'hA0, 0); e(W, 8'h03, 0); e(W, 8'h05, 0); e(P, 0, 0);
    e(S, 0, 0); e(W, 8'hA1, 0); e(RD, 0, 1); e(P, 0, 0);
    exp_rd.push_back(8'h77);
    run(2'd2, 7'h50, 32'h0305, 2, 1, 7'h03, 0);

    // request while busy is ignored
    tag = "R12";
    e(S, 0, 0); e(W, 8'hA0, 0); e(P, 0, 0);
    run(2'd0, 7'h50, 0, 0, 0, 7'h03, 1);
    seen = cmd_seen;
    repeat (12) @(negedge clk);
    check_eq("R12 no commands after ignored request", cmd_seen - seen, 0);
    check_eq("R12 idle again", int'(req_ready), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished (%s)", tag);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule